// File: doc/BRIEF.md
# Fixed-Delay Dual-Clock Elastic Buffer

This block sits at the receiving end of one link between two nodes that run on separate clocks. The sending side pushes one word on every edge of its own clock. The receiving side pulls one word on every edge of its own clock. Neither side ever waits, and there is no handshake. Because both pointers move without pause, the distance between them only changes when the two clock rates differ. That distance is the number of words held in the buffer.

At reset the buffer already holds a fixed number of filler entries, called the preload. So a word that enters on sender tick t comes out on receiver tick t plus the preload. The fill level is sent out in the receiver clock domain as a signed offset from the preload. An external rate controller can use that offset directly as its error term to steer the receiver clock. Two sticky flags report that the fill went outside the storage, which means the fixed delay no longer holds.

The configuration lives in the package. The depth is 16 entries (a power of two), the preload is 8 (always less than the depth), and words are 16 bits wide. Pointers cross between the clock domains as gray code through two-stage synchronizers.

Top module: `llb_elastic_buf`

## Requirements
- R1: On every sender clock edge with `wr_rst` low, the value on `wr_data` is stored and the write pointer advances by one. No enable is involved.
- R2: On every receiver clock edge with `rd_rst` low, one entry is read and the read pointer advances by one, even when the buffer is empty.
- R3: A word written on sender tick t (counting from 0 after both resets are released together) appears on `rd_data` with `rd_valid` = 1 after receiver tick t + 8.
- R4: During reset, and for the first 8 receiver ticks after reset, the read port shows the idle word: `rd_valid` = 0 and `rd_data` = 0. Whenever `rd_valid` is 0, `rd_data` is 0.
- R5: `rd_occ_offset` is a two's-complement value equal to (write count seen in the receiver domain) − (read count). It is 0 in reset. After n receiver ticks with the writer frozen in reset, it is −n. With both sides running, it lags the true fill minus 8 by between 0 and 4 sender ticks.
- R6: `rd_underflow` rises after a receiver tick at which the synchronized fill was 0. It stays at 1 until `rd_rst`. It does not rise while the fill is above 0.
- R7: `wr_overflow` rises after a sender tick at which the synchronized fill was 16, which is the full depth. It stays at 1 until `wr_rst`. It does not rise while the fill is 15 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sender clock |
| wr_rst | input | 1 | Synchronous active-high reset, sender domain |
| wr_data | input | 16 | Word stored on each sender tick |
| wr_overflow | output | 1 | Sticky flag: a write hit a full buffer |
| rd_clk | input | 1 | Receiver clock |
| rd_rst | input | 1 | Synchronous active-high reset, receiver domain |
| rd_valid | output | 1 | 1 for a sent word, 0 for a filler entry |
| rd_data | output | 16 | Word delivered on each receiver tick |
| rd_occ_offset | output | 6 | Signed fill level minus the preload, receiver domain |
| rd_underflow | output | 1 | Sticky flag: a read hit an empty buffer |

## Verification
A read pointer that is off by even one shows up at once on `rd_data`. It also shows up as a wrong value on `rd_occ_offset` on the first receiver tick after the error. A bad preload, or a bad reset value in the synchronizer, shifts every delivered word. It also moves the offset away from 0 while in reset. A broken gray crossing or full/empty compare either corrupts the offset within a few ticks, or makes a flag rise one tick too early or too late at the exact boundaries (fill 0 and fill 16). The bench drives the block up to those boundaries tick by tick.

// File: rtl/llb_pkg.sv
package llb_pkg;

    // Configuration of the buffer
    parameter int LLB_DATA_W      = 16;
    parameter int LLB_ADDR_W      = 4;
    parameter int LLB_PRELOAD     = 8;
    parameter int LLB_SYNC_STAGES = 2;

    // Derived sizes
    localparam int LLB_DEPTH = 1 << LLB_ADDR_W;
    localparam int LLB_PTR_W = LLB_ADDR_W + 1;
    localparam int LLB_OCC_W = LLB_ADDR_W + 2;

    typedef logic [LLB_PTR_W-1:0]         ptr_t;
    typedef logic [LLB_ADDR_W-1:0]        addr_t;
    typedef logic signed [LLB_OCC_W-1:0]  occ_t;

    // One storage entry: a marker bit plus the payload
    typedef struct packed {
        logic                  valid;
        logic [LLB_DATA_W-1:0] data;
    } word_t;

    localparam word_t LLB_IDLE_WORD = '0;
    localparam ptr_t  LLB_WR_INIT   = ptr_t'(LLB_PRELOAD);
    localparam ptr_t  LLB_PTR_ONE   = ptr_t'(1);
    localparam ptr_t  LLB_FULL_FILL = ptr_t'(LLB_DEPTH);

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[LLB_PTR_W-1] = g[LLB_PTR_W-1];
        for (int i = LLB_PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Fill level expressed relative to the preload
    function automatic occ_t fill_offset(input ptr_t fill);
        return occ_t'({1'b0, fill}) - occ_t'(LLB_PRELOAD);
    endfunction

endpackage

// File: rtl/llb_gray_sync.sv
module llb_gray_sync
    import llb_pkg::*;
#(
    parameter ptr_t RST_VAL = '0
) (
    input  logic clk,
    input  logic rst,
    input  ptr_t gray_in,
    output ptr_t gray_out
);

    ptr_t stage_q [LLB_SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LLB_SYNC_STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= gray_in;
            for (int s = 1; s < LLB_SYNC_STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign gray_out = stage_q[LLB_SYNC_STAGES-1];

endmodule

// File: rtl/llb_wr_ctrl.sv
module llb_wr_ctrl
    import llb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ptr_t  rd_gray_s,
    output addr_t wr_addr,
    output ptr_t  wr_gray,
    output logic  overflow
);

    ptr_t ptr_q;
    ptr_t ptr_nx;
    ptr_t rd_bin;
    ptr_t fill;
    logic full;

    always_comb begin
        ptr_nx = ptr_q + LLB_PTR_ONE;
        rd_bin = gray2bin(rd_gray_s);
        fill   = ptr_q - rd_bin;
        full   = (fill == LLB_FULL_FILL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= LLB_WR_INIT;
            wr_gray  <= bin2gray(LLB_WR_INIT);
            overflow <= 1'b0;
        end else begin
            ptr_q    <= ptr_nx;
            wr_gray  <= bin2gray(ptr_nx);
            overflow <= overflow | full;
        end
    end

    assign wr_addr = ptr_q[LLB_ADDR_W-1:0];

    // R1: the pointer steps once per tick, no gating
    p_wr_step_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ptr_q == $past(ptr_q) + LLB_PTR_ONE)
        else $error("write pointer did not advance");

    // R5: the published gray value changes by at most one bit
    p_wr_gray_step_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $countones(wr_gray ^ $past(wr_gray)) <= 1)
        else $error("write gray pointer moved more than one bit");

    // R7: a write at full depth raises the flag
    p_oflow_set_r7: assert property (@(posedge clk) disable iff (rst)
        full |=> overflow)
        else $error("overflow missed");

    // R7: the flag holds until reset
    p_oflow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow)
        else $error("overflow flag dropped");

endmodule

// File: rtl/llb_rd_ctrl.sv
module llb_rd_ctrl
    import llb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ptr_t  wr_gray_s,
    output addr_t rd_addr,
    output ptr_t  rd_gray,
    output occ_t  occ_offset,
    output logic  underflow
);

    ptr_t ptr_q;
    ptr_t ptr_nx;
    ptr_t wr_bin;
    ptr_t fill;
    logic empty;

    always_comb begin
        ptr_nx = ptr_q + LLB_PTR_ONE;
        wr_bin = gray2bin(wr_gray_s);
        fill   = wr_bin - ptr_q;
        empty  = (fill == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            rd_gray   <= '0;
            underflow <= 1'b0;
        end else begin
            ptr_q     <= ptr_nx;
            rd_gray   <= bin2gray(ptr_nx);
            underflow <= underflow | empty;
        end
    end

    assign rd_addr    = ptr_q[LLB_ADDR_W-1:0];
    assign occ_offset = fill_offset(fill);

    // R2: the read pointer steps once per tick, even when empty
    p_rd_step_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ptr_q == $past(ptr_q) + LLB_PTR_ONE)
        else $error("read pointer did not advance");

    // R5: the published gray value changes by at most one bit
    p_rd_gray_step_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $countones(rd_gray ^ $past(rd_gray)) <= 1)
        else $error("read gray pointer moved more than one bit");

    // R6: a read at zero fill raises the flag
    p_uflow_set_r6: assert property (@(posedge clk) disable iff (rst)
        empty |=> underflow)
        else $error("underflow missed");

    // R6: the flag holds until reset
    p_uflow_hold_r6: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow)
        else $error("underflow flag dropped");

endmodule

// File: rtl/llb_store.sv
module llb_store
    import llb_pkg::*;
(
    input  logic                  wr_clk,
    input  logic                  wr_rst,
    input  addr_t                 wr_addr,
    input  logic [LLB_DATA_W-1:0] wr_data,
    input  logic                  rd_clk,
    input  logic                  rd_rst,
    input  addr_t                 rd_addr,
    output word_t                 rd_word
);

    word_t cells [LLB_DEPTH];

    // One register per entry; reset turns every entry into filler
    for (genvar e = 0; e < LLB_DEPTH; e++) begin : g_cell
        word_t cell_q;
        always_ff @(posedge wr_clk) begin
            if (wr_rst) begin
                cell_q <= LLB_IDLE_WORD;
            end else if (wr_addr == addr_t'(e)) begin
                cell_q <= '{valid: 1'b1, data: wr_data};
            end
        end
        assign cells[e] = cell_q;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_word <= LLB_IDLE_WORD;
        end else begin
            rd_word <= cells[rd_addr];
        end
    end

    // R4: a filler entry always carries an all-zero payload
    p_idle_zero_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_word.valid |-> rd_word.data == '0)
        else $error("filler word with nonzero payload");

endmodule

// File: rtl/llb_elastic_buf.sv
module llb_elastic_buf
    import llb_pkg::*;
(
    input  logic                  wr_clk,
    input  logic                  wr_rst,
    input  logic [LLB_DATA_W-1:0] wr_data,
    output logic                  wr_overflow,
    input  logic                  rd_clk,
    input  logic                  rd_rst,
    output logic                  rd_valid,
    output logic [LLB_DATA_W-1:0] rd_data,
    output logic [LLB_OCC_W-1:0]  rd_occ_offset,
    output logic                  rd_underflow
);

    addr_t wr_addr;
    addr_t rd_addr;
    ptr_t  wr_gray;
    ptr_t  rd_gray;
    ptr_t  wr_gray_s;
    ptr_t  rd_gray_s;
    occ_t  occ_offset;
    word_t rd_word;

    llb_wr_ctrl u_wr (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .rd_gray_s (rd_gray_s),
        .wr_addr   (wr_addr),
        .wr_gray   (wr_gray),
        .overflow  (wr_overflow)
    );

    llb_gray_sync #(.RST_VAL(ptr_t'(0))) u_rd_to_wr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .gray_in  (rd_gray),
        .gray_out (rd_gray_s)
    );

    llb_gray_sync #(.RST_VAL(bin2gray(LLB_WR_INIT))) u_wr_to_rd (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .gray_in  (wr_gray),
        .gray_out (wr_gray_s)
    );

    llb_rd_ctrl u_rd (
        .clk        (rd_clk),
        .rst        (rd_rst),
        .wr_gray_s  (wr_gray_s),
        .rd_addr    (rd_addr),
        .rd_gray    (rd_gray),
        .occ_offset (occ_offset),
        .underflow  (rd_underflow)
    );

    llb_store u_store (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    assign rd_valid      = rd_word.valid;
    assign rd_data       = rd_word.data;
    assign rd_occ_offset = occ_offset;

endmodule

// File: tb/llb_elastic_buf_tb_top.sv
module llb_elastic_buf_tb_top;
    import llb_pkg::*;

    logic                  wr_clk = 1'b0;
    logic                  rd_clk = 1'b0;
    logic                  wr_rst = 1'b1;
    logic                  rd_rst = 1'b1;
    logic [LLB_DATA_W-1:0] wr_data = '0;
    logic                  wr_overflow;
    logic                  rd_valid;
    logic [LLB_DATA_W-1:0] rd_data;
    logic [LLB_OCC_W-1:0]  rd_occ_offset;
    logic                  rd_underflow;

    bit wr_run = 1'b1;
    bit rd_run = 1'b1;
    bit chk_en = 1'b0;
    bit zero_mode = 1'b0;
    bit finished = 1'b0;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [LLB_DATA_W-1:0] hist [1024];

    llb_elastic_buf dut_i (
        .wr_clk        (wr_clk),
        .wr_rst        (wr_rst),
        .wr_data       (wr_data),
        .wr_overflow   (wr_overflow),
        .rd_clk        (rd_clk),
        .rd_rst        (rd_rst),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_occ_offset (rd_occ_offset),
        .rd_underflow  (rd_underflow)
    );

    // 50 MHz on both sides, receiver shifted by 7 ns, each can be frozen low
    always begin
        #10;
        if (wr_run) wr_clk = ~wr_clk;
    end
    initial begin
        #7;
        forever begin
            #10;
            if (rd_run) rd_clk = ~rd_clk;
        end
    end

    always @(posedge wr_clk) if (wr_rst) wr_cnt = 0; else wr_cnt++;
    always @(posedge rd_clk) if (rd_rst) rd_cnt = 0; else rd_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sender stimulus: new word after each falling edge, remembered by tick index
    initial begin
        void'($urandom(32'h5EED_0C1A));
        forever begin
            @(negedge wr_clk);
            wr_data = zero_mode ? '0 : LLB_DATA_W'($urandom);
            hist[wr_cnt % 1024] = wr_data;
        end
    end

    // Streaming checker for the read port and the fill offset
    int idx;
    int true_off;
    int rep;
    logic [LLB_DATA_W-1:0] exp_word;
    always @(negedge rd_clk) begin
        if (chk_en) begin
            idx = rd_cnt - 1;
            if (idx < LLB_PRELOAD) begin
                check(rd_valid == 1'b0, "R4 filler valid", int'(rd_valid), 0);
                check(rd_data == '0, "R4 filler data", int'(rd_data), 0);
            end else begin
                exp_word = hist[(idx - LLB_PRELOAD) % 1024];
                check(rd_valid == 1'b1, "R3 word valid", int'(rd_valid), 1);
                check(rd_data == exp_word, "R1 R3 word data", int'(rd_data), int'(exp_word));
            end
            true_off = wr_cnt - rd_cnt;
            rep = int'(occ_t'(rd_occ_offset));
            check(rep <= true_off && rep >= true_off - 4, "R5 running offset", rep, true_off);
        end
    end

    task automatic assert_both_resets();
        @(negedge wr_clk);
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic stream_run(input int ticks);
        assert_both_resets();
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        chk_en = 1'b1;
        repeat (ticks) @(negedge rd_clk);
        chk_en = 1'b0;
        #1;
        check(rd_underflow == 1'b0, "R6 no false underflow", int'(rd_underflow), 0);
        check(wr_overflow == 1'b0, "R7 no false overflow", int'(wr_overflow), 0);
    endtask

    initial begin
        // Reset state
        repeat (5) @(negedge wr_clk);
        check(rd_valid == 1'b0, "R4 reset valid", int'(rd_valid), 0);
        check(rd_data == '0, "R4 reset data", int'(rd_data), 0);
        check(rd_occ_offset == '0, "R5 reset offset", int'(occ_t'(rd_occ_offset)), 0);
        check(rd_underflow == 1'b0, "R6 reset underflow", int'(rd_underflow), 0);
        check(wr_overflow == 1'b0, "R7 reset overflow", int'(wr_overflow), 0);

        // Random payload stream with equal rates
        stream_run(600);

        // All-zero payload: must still be marked valid, unlike filler
        zero_mode = 1'b1;
        stream_run(200);
        zero_mode = 1'b0;

        // Drain with the writer frozen: exact offsets, then underflow
        assert_both_resets();
        wr_run = 1'b0;
        @(negedge rd_clk);
        rd_rst = 1'b0;
        for (int n = 1; n <= LLB_PRELOAD; n++) begin
            @(negedge rd_clk);
            check(int'(occ_t'(rd_occ_offset)) == -n, "R2 R5 drain offset",
                  int'(occ_t'(rd_occ_offset)), -n);
            check(rd_underflow == 1'b0, "R6 not yet empty", int'(rd_underflow), 0);
            check(rd_valid == 1'b0, "R4 filler during drain", int'(rd_valid), 0);
        end
        @(negedge rd_clk);
        check(rd_underflow == 1'b1, "R6 read at empty", int'(rd_underflow), 1);
        repeat (5) @(negedge rd_clk);
        check(rd_underflow == 1'b1, "R6 sticky", int'(rd_underflow), 1);
        rd_rst = 1'b1;
        repeat (2) @(negedge rd_clk);
        check(rd_underflow == 1'b0, "R6 cleared by reset", int'(rd_underflow), 0);
        wr_run = 1'b1;

        // Fill with the reader frozen: flag exactly on the write at full depth
        assert_both_resets();
        @(negedge rd_clk);
        rd_run = 1'b0;
        @(negedge wr_clk);
        wr_rst = 1'b0;
        for (int k = 1; k <= LLB_DEPTH - LLB_PRELOAD; k++) begin
            @(negedge wr_clk);
            check(wr_overflow == 1'b0, "R7 below full", int'(wr_overflow), 0);
        end
        @(negedge wr_clk);
        check(wr_overflow == 1'b1, "R7 write at full", int'(wr_overflow), 1);
        repeat (3) @(negedge wr_clk);
        check(wr_overflow == 1'b1, "R7 sticky", int'(wr_overflow), 1);
        wr_rst = 1'b1;
        repeat (2) @(negedge wr_clk);
        check(wr_overflow == 1'b0, "R7 cleared by reset", int'(wr_overflow), 0);
        rd_run = 1'b1;

        // A second random stream after all the corner cases
        stream_run(300);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule